// File: doc/BRIEF.md
# Atomic Two-Byte Temperature Register

This block holds a 16-bit temperature result and shows it to a byte-wide register read port as a high-byte register and a low-byte register. New results arrive on an update strobe in the same clock domain. The full 16-bit value goes out at all times on a separate output for fan-control logic. Bits below the 10-bit guaranteed resolution are kept as they are and are not masked.

A host gets an atomic reading by reading one byte and then, as its very next read, the other byte. The first byte read while the block is unlocked (state `ST_OPEN`) copies the current value into a snapshot. The block then moves to `ST_LOCKED`, and the partner byte is served from that snapshot. The next read to any address ends the lock (transition LOCKED to OPEN, taken on any read). Reads that start a lock take the OPEN to LOCKED transition. Reads to any other address keep the block in OPEN, return a fixed pattern and start no lock.

The read data is registered. It shows the result of a read one clock after the read strobe and keeps that value until the next read.

Top module: `tempreg_locked`

## Requirements
- R1: After reset, `rd_data` and `fan_temp` are 0 and the block is unlocked: the first read of a byte returns the live value.
- R2: While unlocked, a read of address 2 returns bits [15:8] of the latest update, and a read of address 3 returns bits [7:0]. An update is counted if its strobe came in an earlier cycle. All bits are passed through unmasked.
- R3: A read of address 2 or 3 while unlocked sets the lock. Updates after that do not change the byte returned by the next read of either byte address.
- R4: The read that follows a locking read, at any address, returns data from the snapshot if it is a byte address, and it releases the lock. Later byte reads return live data again.
- R5: A read of any address other than 2 and 3 returns 8'hA5, clears any active lock, and never sets one.
- R6: If an update and a locking read fall in the same cycle, the returned byte and the snapshot both hold the value from before that update.
- R7: `fan_temp` equals the data of the most recent update from the cycle after its strobe, whether or not the block is locked.
- R8: `rd_data` changes only one cycle after a read strobe. Otherwise it holds its value, even across updates.
- R9: A second read of the same byte address while locked returns the snapshot byte and releases the lock. It does not lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | New conversion result strobe |
| upd_data | input | 16 | New conversion result |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | 4 | Register address |
| rd_data | output | 8 | Registered read data |
| fan_temp | output | 16 | Live full-precision value for fan control |

## Verification
The assertions assume that `rd_en` is a single-cycle strobe per read and that `rd_addr` is stable while it is high. They also assume that `upd_valid` may fall in any cycle, including a read cycle. The bench drives every input on the falling edge and pulses `rd_en` for exactly one clock. It sweeps every pair of first and second addresses, with an update placed between the two reads. It also places updates in the same cycle as reads to exercise the pre-update sampling rule.

// File: rtl/tr_pkg.sv
package tr_pkg;
    typedef enum logic {
        ST_OPEN,
        ST_LOCKED
    } lock_state_e;

    typedef enum logic [1:0] {
        RG_HIGH,
        RG_LOW,
        RG_OTHER
    } region_e;
endpackage

// File: rtl/tr_addr_decode.sv
module tr_addr_decode
    import tr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int HI_ADDR = 2,
    parameter int LO_ADDR = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);

    always_comb begin
        if (addr == HI_A)      region = RG_HIGH;
        else if (addr == LO_A) region = RG_LOW;
        else                   region = RG_OTHER;
    end
endmodule

// File: rtl/tr_lock_fsm.sv
module tr_lock_fsm
    import tr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  region_e     region,
    output lock_state_e state,
    output logic        capture,
    output logic        use_snap
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        capture  = 1'b0;
        use_snap = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (rd_en && region != RG_OTHER) begin
                    capture = 1'b1;
                    state_d = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                use_snap = 1'b1;
                if (rd_en) state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    assign state = state_q;

    a_r3_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && rd_en && region != RG_OTHER) |=> state_q == ST_LOCKED);
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && rd_en) |=> state_q == ST_OPEN);
    a_r5_no_lock_other: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && rd_en && region == RG_OTHER) |=> state_q == ST_OPEN);
endmodule

// File: rtl/tr_sample_store.sv
module tr_sample_store #(
    parameter int TEMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [TEMP_W-1:0] upd_data,
    input  logic              capture,
    output logic [TEMP_W-1:0] live,
    output logic [TEMP_W-1:0] snap
);
    logic [TEMP_W-1:0] live_q, snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            snap_q <= '0;
        end else begin
            if (upd_valid) live_q <= upd_data;
            if (capture)   snap_q <= live_q;
        end
    end

    assign live = live_q;
    assign snap = snap_q;

    a_r6_snap_pre_update: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> snap_q == $past(live_q));
    a_r3_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap_q));
endmodule

// File: rtl/tempreg_locked.sv
module tempreg_locked
    import tr_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter int          ADDR_W  = 4,
    parameter int          HI_ADDR = 2,
    parameter int          LO_ADDR = 3,
    parameter logic [7:0]  FILL    = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_valid,
    input  logic [2*DATA_W-1:0]   upd_data,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [2*DATA_W-1:0]   fan_temp
);
    localparam int TEMP_W = 2 * DATA_W;

    region_e           region;
    lock_state_e       state;
    logic              capture, use_snap;
    logic [TEMP_W-1:0] live, snap, src;
    logic [DATA_W-1:0] rd_q, rd_d;

    tr_addr_decode #(.ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_dec (
        .addr   (rd_addr),
        .region (region)
    );

    tr_lock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .region   (region),
        .state    (state),
        .capture  (capture),
        .use_snap (use_snap)
    );

    tr_sample_store #(.TEMP_W(TEMP_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_data  (upd_data),
        .capture   (capture),
        .live      (live),
        .snap      (snap)
    );

    assign src = use_snap ? snap : live;

    always_comb begin
        unique case (region)
            RG_HIGH: rd_d = src[TEMP_W-1:DATA_W];
            RG_LOW:  rd_d = src[DATA_W-1:0];
            default: rd_d = DATA_W'(FILL);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_d;
    end

    assign rd_data  = rd_q;
    assign fan_temp = live;

    a_r7_fan_follows: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> fan_temp == $past(upd_data));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    a_r5_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RG_OTHER) |=> rd_data == DATA_W'(FILL));
    a_r6_read_pre_update: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && rd_en && region == RG_HIGH) |=> rd_data == $past(live[TEMP_W-1:DATA_W]));
    a_r4_locked_from_snap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && rd_en && region == RG_LOW) |=> rd_data == $past(snap[DATA_W-1:0]));
endmodule

// File: tb/tempreg_locked_bench.sv
module tempreg_locked_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [15:0] upd_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] fan_temp;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_live = '0;
    logic [15:0] m_snap = '0;
    bit          m_locked = 1'b0;

    always #2 clk = ~clk;

    tempreg_locked u_tempreg_locked (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_data(upd_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .fan_temp(fan_temp)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic update(logic [15:0] v);
        @(negedge clk);
        upd_valid = 1'b1; upd_data = v;
        @(negedge clk);
        upd_valid = 1'b0;
        m_live = v;
        check("R7", fan_temp, v);
    endtask

    // read with optional same-cycle update; model from requirements
    task automatic rd(string tag, logic [3:0] a, bit with_upd, logic [15:0] v);
        logic [15:0] s;
        logic [7:0]  e;
        s = m_locked ? m_snap : m_live;
        if (a == 4'd2)      e = s[15:8];
        else if (a == 4'd3) e = s[7:0];
        else                e = 8'hA5;
        if (m_locked) m_locked = 1'b0;
        else if (a == 4'd2 || a == 4'd3) begin
            m_snap = m_live; m_locked = 1'b1;
        end
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        upd_valid = with_upd; upd_data = v;
        @(negedge clk);
        rd_en = 1'b0; upd_valid = 1'b0;
        if (with_upd) m_live = v;
        check(tag, {8'h00, rd_data}, {8'h00, e});
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {8'h00, rd_data}, 16'h0000);
        check("R1", fan_temp, 16'h0000);
        rst_n = 1'b1;
        // R1: unlocked after reset, read returns live value
        update(16'h3C81);
        rd("R1", 4'd2, 1'b0, '0);
        rd("R4", 4'd0, 1'b0, '0);
        // R8: idle with updates leaves rd_data alone
        update(16'h1111);
        check("R8", {8'h00, rd_data}, 16'h00A5);
        // R2: every bit unmasked, both bytes
        for (int k = 0; k < 16; k++) begin
            update(16'(1 << k));
            rd("R2", 4'd3, 1'b0, '0);
            rd("R2", 4'd2, 1'b0, '0);
        end
        // R6: update in same cycle as locking read
        update(16'hABCD);
        rd("R6", 4'd3, 1'b1, 16'h1234);
        rd("R6", 4'd2, 1'b0, '0);
        rd("R6", 4'd2, 1'b0, '0);
        // R9: same byte twice while locked, then live again
        update(16'h5A0F);
        rd("R9", 4'd2, 1'b0, '0);
        update(16'h77E1);
        rd("R9", 4'd2, 1'b0, '0);
        rd("R9", 4'd2, 1'b0, '0);
        rd("R4", 4'd7, 1'b0, '0);
        // R3/R4/R5: every first/second address pair with update between
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [15:0] v1, v2;
                v1 = 16'((a * 16 + b) * 16'h9E37 + 16'h0101);
                v2 = ~v1 ^ 16'h5AA5;
                update(v1);
                rd((a == 2 || a == 3) ? "R2" : "R5", 4'(a), 1'b0, '0);
                update(v2);
                rd((a == 2 || a == 3) ? "R3" : "R5", 4'(b), 1'b0, '0);
                rd("R4", 4'd2, 1'b0, '0);
                rd("R5", 4'd9, 1'b0, '0);
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule